// File: doc/BRIEF.md
# Low-Power DRAM Power-State Controller

This block models, on the device side of a low-power DRAM, how the part chooses and leaves its low-power states. On every clock edge it looks at clock enable, an active-low chip select and three command/address bits. While clock enable stays high it follows row activate and precharge commands, so it knows whether a row is open (ACTIVE) or every bank is closed (IDLE).

The command seen in the first cycle that clock enable is low chooses the low-power state. With a row open the device freezes in ACTIVE_PD. From IDLE, a no-operation (or any command other than the two below) gives IDLE_PD, a refresh gives SELF_REFRESH and a burst terminate gives DEEP_PD, which discards the memory contents. When clock enable returns high, ACTIVE_PD goes back to ACTIVE, and IDLE_PD and SELF_REFRESH go back to IDLE. DEEP_PD goes to UNINIT instead. UNINIT ignores everything until the reset input is pulsed. The state names and transitions are: IDLE→ACTIVE (activate), ACTIVE→IDLE (precharge), IDLE/ACTIVE→low-power state (clock-enable fall), low-power state→IDLE/ACTIVE (clock-enable rise), DEEP_PD→UNINIT (clock-enable rise), any→IDLE (reset).

Top module: `lpsc_top`

## Requirements
- R1: After reset, `pstate` is IDLE (code 0), `contents_valid` is 1 and `reset_needed` is 0.
- R2: With `cke` high in the current and previous cycle and `cs_n` low, an activate (`ca[1:0]`=2'b10, i.e. CA0 low and CA1 high, CA2 either value) moves IDLE to ACTIVE (code 1), and a precharge (`ca`=3'b101) moves ACTIVE to IDLE. The new state shows after the next clock edge.
- R3: While `cs_n` is high, every command is a no-operation: with `cke` high the state does not change, whatever `ca` holds.
- R4: If `cke` goes from high to low while the state is ACTIVE, the next state is ACTIVE_PD (code 2), whatever the command is.
- R5: If `cke` goes from high to low in IDLE with a no-operation (`cs_n` high, or `ca`=3'b111) or with any command other than refresh or burst terminate, the next state is IDLE_PD (code 3).
- R6: If `cke` goes from high to low in IDLE with `cs_n` low and a refresh (`ca`=3'b100: CA2 high, CA1 and CA0 low), the next state is SELF_REFRESH (code 4).
- R7: If `cke` goes from high to low in IDLE with `cs_n` low and a burst terminate (`ca`=3'b011: CA0 and CA1 high, CA2 low), the next state is DEEP_PD (code 5) and `contents_valid` drops to 0 on the same edge.
- R8: Only the first low cycle of `cke` picks the state. While `cke` stays low, the low-power state holds and all commands are ignored.
- R9: When `cke` is high in ACTIVE_PD, the next state is ACTIVE. When `cke` is high in IDLE_PD or SELF_REFRESH, the next state is IDLE.
- R10: When `cke` is high in DEEP_PD, the next state is UNINIT (code 6). UNINIT ignores `cke` and all commands. `reset_needed` is 1 in DEEP_PD and UNINIT and 0 in every other state.
- R11: Asserting `rst_n` in UNINIT returns the block to IDLE with `contents_valid` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (the full reset sequence) |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Active-low chip select |
| ca | input | 3 | Command/address bits CA2..CA0 (bit 0 = CA0) |
| pstate | output | 3 | Current power state code |
| reset_needed | output | 1 | High when only a reset can bring the device back |
| contents_valid | output | 1 | Memory contents are still valid |

## Verification
The bench puts a refresh and a burst terminate on the falling cycle while a row is open. A design that checked the command before the open-row flag would then enter self-refresh or deep power-down and lose the active state. It drives self-refresh and deep power-down commands again while `cke` stays low. A design that decoded the command on the low level of `cke` and not on its edge would change state partway through power-down. It raises `cke` out of deep power-down and then issues activates and a second `cke` fall. A design that treated deep power-down like the other power-down states would come back to IDLE without a reset. It also sends a refresh encoding with chip select high. A decoder that did not mask with `cs_n` would pick self-refresh where idle power-down is expected.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

    localparam int CA_BITS    = 3;
    localparam int STATE_BITS = 3;

    // Command/address encodings, bit 0 = CA0
    localparam logic [CA_BITS-1:0] CA_NOP = 3'b111;
    localparam logic [CA_BITS-1:0] CA_REF = 3'b100;
    localparam logic [CA_BITS-1:0] CA_BST = 3'b011;
    localparam logic [CA_BITS-1:0] CA_PRE = 3'b101;
    localparam logic [1:0]         CA_ACT_LOW2 = 2'b10;

    typedef enum logic [STATE_BITS-1:0] {
        PS_IDLE      = 3'd0,
        PS_ACTIVE    = 3'd1,
        PS_ACTIVE_PD = 3'd2,
        PS_IDLE_PD   = 3'd3,
        PS_SELF_REF  = 3'd4,
        PS_DEEP_PD   = 3'd5,
        PS_UNINIT    = 3'd6
    } pstate_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_PRE   = 3'd2,
        CMD_REF   = 3'd3,
        CMD_BST   = 3'd4,
        CMD_OTHER = 3'd5
    } cmd_e;

endpackage

// File: rtl/lpsc_cmd_decode.sv
module lpsc_cmd_decode
    import lpsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke,
    input  logic               cs_n,
    input  logic [CA_BITS-1:0] ca,
    output cmd_e               cmd,
    output logic               cke_fall,
    output logic               cke_steady
);

    logic cke_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cke;
    end

    assign cke_fall   = cke_q & ~cke;
    assign cke_steady = cke_q & cke;

    always_comb begin
        if (cs_n)                        cmd = CMD_NOP;
        else if (ca == CA_NOP)           cmd = CMD_NOP;
        else if (ca[1:0] == CA_ACT_LOW2) cmd = CMD_ACT;
        else if (ca == CA_PRE)           cmd = CMD_PRE;
        else if (ca == CA_REF)           cmd = CMD_REF;
        else if (ca == CA_BST)           cmd = CMD_BST;
        else                             cmd = CMD_OTHER;
    end

    // R3
    nop_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (cmd == CMD_NOP));

endmodule

// File: rtl/lpsc_fsm.sv
module lpsc_fsm
    import lpsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cke_fall,
    input  logic                  cke_steady,
    input  cmd_e                  cmd,
    output logic [STATE_BITS-1:0] pstate,
    output logic                  reset_needed,
    output logic                  contents_valid
);

    pstate_e state_q, state_d;
    logic    valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (cke_fall) begin
                    unique case (cmd)
                        CMD_REF: state_d = PS_SELF_REF;
                        CMD_BST: state_d = PS_DEEP_PD;
                        default: state_d = PS_IDLE_PD;
                    endcase
                end else if (cke_steady && cmd == CMD_ACT) begin
                    state_d = PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (cke_fall)                              state_d = PS_ACTIVE_PD;
                else if (cke_steady && cmd == CMD_PRE)     state_d = PS_IDLE;
            end
            PS_ACTIVE_PD: if (cke) state_d = PS_ACTIVE;
            PS_IDLE_PD:   if (cke) state_d = PS_IDLE;
            PS_SELF_REF:  if (cke) state_d = PS_IDLE;
            PS_DEEP_PD:   if (cke) state_d = PS_UNINIT;
            PS_UNINIT:    state_d = PS_UNINIT;
            default:      state_d = PS_UNINIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    valid_q <= 1'b1;
        else if (state_d == PS_DEEP_PD) valid_q <= 1'b0;
    end

    always_comb begin
        pstate         = state_q;
        contents_valid = valid_q;
        reset_needed   = (state_q == PS_DEEP_PD) || (state_q == PS_UNINIT);
    end

    // R4
    open_row_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ACTIVE && cke_fall) |=> (state_q == PS_ACTIVE_PD));

    // R7
    deep_pd_loses_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DEEP_PD) |-> !valid_q);

    // R8
    low_power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_ACTIVE_PD || state_q == PS_IDLE_PD ||
          state_q == PS_SELF_REF  || state_q == PS_DEEP_PD) && !cke)
        |=> (state_q == $past(state_q)));

    // R9
    active_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ACTIVE_PD && cke) |=> (state_q == PS_ACTIVE));

    // R10
    uninit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_UNINIT) |=> (state_q == PS_UNINIT));

endmodule

// File: rtl/lpsc_top.sv
module lpsc_top
    import lpsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic [CA_BITS-1:0]    ca,
    output logic [STATE_BITS-1:0] pstate,
    output logic                  reset_needed,
    output logic                  contents_valid
);

    cmd_e cmd;
    logic cke_fall;
    logic cke_steady;

    lpsc_cmd_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ca         (ca),
        .cmd        (cmd),
        .cke_fall   (cke_fall),
        .cke_steady (cke_steady)
    );

    lpsc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cke            (cke),
        .cke_fall       (cke_fall),
        .cke_steady     (cke_steady),
        .cmd            (cmd),
        .pstate         (pstate),
        .reset_needed   (reset_needed),
        .contents_valid (contents_valid)
    );

endmodule

// File: tb/lpsc_top_tb.sv
module lpsc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic [2:0] ca = 3'b111;
    logic [2:0] pstate;
    logic       reset_needed;
    logic       contents_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [2:0] A_NOP = 3'b111;
    localparam logic [2:0] A_ACT = 3'b010;
    localparam logic [2:0] A_PRE = 3'b101;
    localparam logic [2:0] A_REF = 3'b100;
    localparam logic [2:0] A_BST = 3'b011;

    localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_APD = 3'd2,
                           S_IPD = 3'd3, S_SR = 3'd4, S_DPD = 3'd5, S_UNI = 3'd6;

    always #5 clk = ~clk;

    lpsc_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cke            (cke),
        .cs_n           (cs_n),
        .ca             (ca),
        .pstate         (pstate),
        .reset_needed   (reset_needed),
        .contents_valid (contents_valid)
    );

    task automatic cyc(input logic k, input logic c, input logic [2:0] a);
        cke = k; cs_n = c; ca = a;
        @(posedge clk); #2;
    endtask

    task automatic chk(input string req, input logic [2:0] es, input logic ev, input logic en);
        checks++;
        if (pstate !== es || contents_valid !== ev || reset_needed !== en) begin
            fails++;
            $display("FAIL %s: state=%0d valid=%0b need=%0b expected state=%0d valid=%0b need=%0b",
                     req, pstate, contents_valid, reset_needed, es, ev, en);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ca = A_NOP;
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1;
        cyc(1'b1, 1'b1, A_NOP);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset state", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic t_row_tracking();
        cyc(1'b1, 1'b0, A_ACT);  chk("R2 activate", S_ACT, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_PRE);  chk("R3 deselected precharge", S_ACT, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, A_PRE);  chk("R2 precharge", S_IDLE, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_ACT);  chk("R3 deselected activate", S_IDLE, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 3'b110); chk("R2 activate CA2 high", S_ACT, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, A_PRE);  chk("R2 precharge again", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic t_active_pd();
        cyc(1'b1, 1'b0, A_ACT);
        cyc(1'b0, 1'b0, A_REF);  chk("R4 refresh with row open", S_APD, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_BST);  chk("R8 hold active pd", S_APD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);  chk("R9 wake to active", S_ACT, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_BST);  chk("R4 bst with row open", S_APD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);
        cyc(1'b1, 1'b0, A_PRE);  chk("R2 close after wake", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic t_idle_pd();
        cyc(1'b0, 1'b1, A_REF);  chk("R5 deselected refresh", S_IPD, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_REF);  chk("R8 refresh ignored low", S_IPD, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_ACT);  chk("R8 activate ignored low", S_IPD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);  chk("R9 wake from idle pd", S_IDLE, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_NOP);  chk("R5 nop encoding", S_IPD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);
        cyc(1'b0, 1'b0, A_ACT);  chk("R5 other command", S_IPD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);  chk("R9 wake idle again", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic t_self_refresh();
        cyc(1'b0, 1'b0, A_REF);  chk("R6 self refresh entry", S_SR, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, A_BST);  chk("R8 bst ignored in sr", S_SR, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, A_NOP);  chk("R9 wake from sr", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic t_deep_pd();
        cyc(1'b0, 1'b0, A_BST);  chk("R7 deep pd entry", S_DPD, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, A_REF);  chk("R8 hold deep pd", S_DPD, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, A_NOP);  chk("R10 rise to uninit", S_UNI, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, A_ACT);  chk("R10 activate ignored", S_UNI, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, A_REF);  chk("R10 cke fall ignored", S_UNI, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, A_NOP);  chk("R10 still uninit", S_UNI, 1'b0, 1'b1);
        do_reset();
        chk("R11 reset from uninit", S_IDLE, 1'b1, 1'b0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        t_reset();
        t_row_tracking();
        t_active_pd();
        t_idle_pd();
        t_self_refresh();
        t_deep_pd();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
            $finish;
        end
    end

endmodule